// File: doc/BRIEF.md
# Per-Sector Flash Lock Register Bank

This block keeps two protection bits for each 64 KB sector of a 4 MB serial flash array. The first is a write-lock bit, which makes the controller refuse program and erase operations on that sector. The second is a lock-down bit, which freezes both bits of that sector until the next power-up. The flash controller sends read and write requests to the bank. Each request carries a 22-bit byte address, and the bank returns the addressed sector's lock bits one clock later.

A second port is purely combinational. The program and erase sequencer gives it an address, and the port reports in the same cycle whether the target sector is write-locked. The power-on reset is the only event that clears the bank. No register write can release a sector once its lock-down bit is set.

Top module: `sector_lock_bank`

## Requirements
- R1: A synchronous active-high reset clears both bits of every sector to 0. While reset is high and in the first cycle after it, `rsp_valid` is 0. Reset is also the only way to release a locked-down sector.
- R2: The sector index is address bits [21:16]. Address bits [15:0] have no effect on which sector is read, written or queried.
- R3: A request accepted with `req_valid`=1 is answered exactly one cycle later with `rsp_valid`=1 for one cycle. The response byte holds the write-lock bit in bit 0 and the lock-down bit in bit 1, and bits [7:2] read as 0.
- R4: A write (`req_write`=1) to a sector whose lock-down bit is 0 stores `req_wdata[0]` as write-lock and `req_wdata[1]` as lock-down, and it reports `rsp_applied`=1. Bits [7:2] of `req_wdata` are ignored.
- R5: A write to a sector whose lock-down bit is 1 changes nothing and reports `rsp_applied`=0.
- R6: `qry_blocked` is 1 exactly when the sector of `qry_addr` has its write-lock bit set. It is combinational, with no cycle of latency, and it shows a write from the clock edge that stores it.
- R7: In a cycle after one with no request, `rsp_valid` is 0. A read response always reports `rsp_applied`=0.
- R8: The response to a write carries the sector's lock bits as they stand after that write, in the R3 layout.
- R9: A write changes only the addressed sector. Every other sector keeps its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write lock register, 0 = read lock register |
| req_addr | input | 22 | Byte address selecting the sector |
| req_wdata | input | 8 | Write data, bit 0 write-lock, bit 1 lock-down |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 8 | Lock bits of the sector (after the write, for writes) |
| rsp_applied | output | 1 | Write was stored (0 for rejected writes and for reads) |
| qry_addr | input | 22 | Address of a planned program or erase |
| qry_blocked | output | 1 | Target sector is write-locked |

## Verification
A wrong bit in the lock store shows up at `qry_blocked` in the same cycle that sector is queried. It also appears in the response byte one cycle after any request to that sector. A lock-down bit that fails to stick only shows up on a later write to the same sector: that write then reports `rsp_applied`=1 with new bits instead of 0 with the old ones. The bench therefore runs a reference model on every clock and queries a sector at every step. It also follows locking writes with deliberate overwrite attempts, so that a corrupted bit is seen within one or two cycles of the access that exposes it.

// File: rtl/seclock_pkg.sv
package seclock_pkg;
  // Packed so that bit 0 is the write-lock bit and bit 1 the lock-down bit.
  typedef struct packed {
    logic down;
    logic wlock;
  } lock_t;
  localparam int LOCK_W = 2;
endpackage

// File: rtl/seclock_store.sv
module seclock_store
  import seclock_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SECT_W-1:0] waddr,
  input  lock_t             wbits,
  input  logic [SECT_W-1:0] raddr_a,
  output lock_t             rbits_a,
  input  logic [SECT_W-1:0] raddr_b,
  output lock_t             rbits_b
);
  localparam int NUM_SECT = 1 << SECT_W;

  lock_t mem [NUM_SECT];

  // Flop array: a one-cycle clear of all entries rules out block RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SECT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wbits;
    end
  end

  assign rbits_a = mem[raddr_a];
  assign rbits_b = mem[raddr_b];
endmodule

// File: rtl/seclock_gate.sv
module seclock_gate
  import seclock_pkg::*;
(
  input  logic  valid,
  input  logic  is_write,
  input  lock_t cur,
  input  lock_t req_bits,
  output logic  we,
  output lock_t result,
  output logic  applied
);
  always_comb begin
    we      = valid && is_write && !cur.down;
    applied = we;
    result  = we ? req_bits : cur;
  end
endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank
  import seclock_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 6,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_applied,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_blocked
);
  localparam int PAD_W = DATA_W - LOCK_W;

  logic [SECT_W-1:0] req_sect;
  logic [SECT_W-1:0] qry_sect;
  lock_t             cur_bits;
  lock_t             qry_bits;
  lock_t             new_bits;
  lock_t             req_bits;
  logic              wr_en;
  logic              wr_ok;

  assign req_sect = req_addr[SECT_LSB +: SECT_W];
  assign qry_sect = qry_addr[SECT_LSB +: SECT_W];
  assign req_bits = lock_t'(req_wdata[LOCK_W-1:0]);

  seclock_store #(.SECT_W(SECT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (req_sect),
    .wbits   (new_bits),
    .raddr_a (req_sect),
    .rbits_a (cur_bits),
    .raddr_b (qry_sect),
    .rbits_b (qry_bits)
  );

  seclock_gate u_gate (
    .valid    (req_valid),
    .is_write (req_write),
    .cur      (cur_bits),
    .req_bits (req_bits),
    .we       (wr_en),
    .result   (new_bits),
    .applied  (wr_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_applied <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_rdata   <= {{PAD_W{1'b0}}, new_bits};
        rsp_applied <= wr_ok;
      end
    end
  end

  assign qry_blocked = qry_bits.wlock;
endmodule

// File: rtl/sector_lock_bank_sva.sv
module sector_lock_bank_sva #(
  parameter int ADDR_W   = 22,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 6,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_applied,
  input logic [ADDR_W-1:0] qry_addr,
  input logic              qry_blocked,
  input logic [1:0]        cur_bits
);
  assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_rsp_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[DATA_W-1:2] == '0));

  assert_read_not_applied_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> (!rsp_applied && rsp_rdata[1:0] == $past(cur_bits)));

  assert_open_write_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !cur_bits[1]) |=>
      (rsp_applied && rsp_rdata[1:0] == $past(req_wdata[1:0])));

  assert_frozen_write_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && cur_bits[1]) |=>
      (!rsp_applied && rsp_rdata[1:0] == $past(cur_bits)));

  assert_query_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !cur_bits[1]) |=>
      ((qry_addr[SECT_LSB +: SECT_W] != $past(req_addr[SECT_LSB +: SECT_W])) ||
       (qry_blocked == $past(req_wdata[0]))));
endmodule

bind sector_lock_bank sector_lock_bank_sva #(
  .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .SECT_W(SECT_W), .DATA_W(DATA_W)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_applied (rsp_applied),
  .qry_addr    (qry_addr),
  .qry_blocked (qry_blocked),
  .cur_bits    (cur_bits)
);

// File: tb/sector_lock_bank_test.sv
module sector_lock_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rsp_applied;
  logic [21:0] qry_addr = '0;
  logic        qry_blocked;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model: one entry per sector.
  int m_wl [64];
  int m_ld [64];
  int e_valid = 0;
  int e_rdata = 0;
  int e_applied = 0;
  string e_tag = "R7";

  always #4 clk = ~clk;

  sector_lock_bank uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_applied(rsp_applied), .qry_addr(qry_addr),
    .qry_blocked(qry_blocked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input int sect, input int low);
    return {sect[5:0], low[15:0]};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      m_wl[i] = 0;
      m_ld[i] = 0;
    end
  endtask

  // Called at a negedge: drive, check query, clock, update model, check response.
  task automatic step(input bit v, input bit w, input logic [21:0] a,
                      input logic [7:0] d, input logic [21:0] q);
    int s;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; qry_addr = q;
    #1;
    chk(qry_blocked == (m_wl[q[21:16]] != 0), "R6 query", qry_blocked, m_wl[q[21:16]]);
    @(posedge clk);
    s = a[21:16];
    e_valid = v;
    if (v) begin
      if (!w) begin
        e_tag = "R3 read"; e_applied = 0;
      end else if (m_ld[s] == 0) begin
        m_wl[s] = d[0]; m_ld[s] = d[1];
        e_tag = "R4 open write"; e_applied = 1;
      end else begin
        e_tag = "R5 frozen write"; e_applied = 0;
      end
      e_rdata = (m_ld[s] << 1) | m_wl[s];
    end else begin
      e_tag = "R7 idle";
    end
    @(negedge clk);
    chk(rsp_valid == e_valid[0], e_tag, rsp_valid, e_valid);
    if (e_valid != 0) begin
      chk(rsp_rdata == e_rdata[7:0], w ? "R8 write data" : e_tag, rsp_rdata, e_rdata);
      chk(rsp_applied == e_applied[0], e_tag, rsp_applied, e_applied);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    chk(rsp_valid == 1'b0, "R1 reset valid", rsp_valid, 0);
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();
    // R1: every sector cleared.
    for (int i = 0; i < 64; i++) step(1, 0, mk(i, i * 977), 8'h00, mk(i, 5));
    // R4 R8: set write lock on sector 5, upper data bits ignored.
    step(1, 1, mk(5, 16'h1234), 8'hFD, mk(5, 16'hFFFF));
    // R2: low address bits do not change the sector.
    step(1, 0, mk(5, 16'hABCD), 8'h00, mk(5, 16'h0001));
    chk(rsp_rdata == 8'h01, "R2 low bits", rsp_rdata, 1);
    step(1, 1, mk(5, 0), 8'h00, mk(5, 0));
    // R5: lock down sector 9 then try to clear it.
    step(1, 1, mk(9, 7), 8'h03, mk(9, 0));
    step(1, 1, mk(9, 8), 8'h00, mk(9, 0));
    chk(rsp_applied == 1'b0 && rsp_rdata == 8'h03, "R5 sticky", rsp_rdata, 3);
    step(1, 1, mk(9, 8), 8'h01, mk(9, 0));
    // R9: neighbours untouched.
    step(1, 0, mk(8, 0), 8'h00, mk(10, 0));
    chk(rsp_rdata == 8'h00, "R9 neighbour", rsp_rdata, 0);
    step(1, 0, mk(10, 0), 8'h00, mk(8, 0));
    chk(rsp_rdata == 8'h00, "R9 neighbour", rsp_rdata, 0);
    // Lock-down without write lock on the top sector.
    step(1, 1, mk(63, 0), 8'h02, mk(63, 0));
    step(1, 1, mk(63, 1), 8'h01, mk(63, 0));
    step(0, 0, mk(0, 0), 8'h00, mk(63, 0));
    // Random mix with idle cycles.
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, $urandom % 2, 22'($urandom), 8'($urandom), 22'($urandom));
    // R1: reset releases locked-down sectors.
    do_reset();
    step(1, 0, mk(9, 0), 8'h00, mk(9, 0));
    chk(rsp_rdata == 8'h00, "R1 release", rsp_rdata, 0);
    step(1, 1, mk(9, 0), 8'h01, mk(9, 0));
    chk(rsp_applied == 1'b1, "R1 writable again", rsp_applied, 1);
    for (int i = 0; i < 64; i++) step(1, 0, mk(i, 0), 8'h00, mk(63 - i, 3));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule